// File: doc/BRIEF.md
# Cycle-Period FSK Tone Discriminator

This block turns a clipped, one-bit IF square wave into a demodulated data level. The wave carries one of two tones placed either side of a 1 kHz centre, and the block runs on a 1 MHz sample clock. It brings the input into the clock domain and divides it by two on rising edges. After that, every level of the divided signal lasts exactly one IF period, measured from one rising edge to the next.

Each polarity of the divided signal has its own down-counter. That counter is reloaded at the start of its level and counts only while the level is present. If the level outlasts a programmable load value, the counter emits a one-clock overflow pulse. The counter then reloads and keeps pulsing for as long as the level lasts. The two overflow streams are ORed together into one stream, which retriggers a pulse stretcher. The stretcher's output is the data bit: high while slow (long-period) cycles arrive and low while fast ones arrive.

The decision is made once per IF cycle, so the output timing follows the number of slow cycles received and does not depend on the bit rate.

Top module: `fsk_cycle_discriminator`

## Requirements
- R1: While `rst` is high, and after it is released, `data_o` is 0. It stays 0 until some IF period longer than the threshold has been seen, so a static input never raises it.
- R2: The period is taken from one rising edge of `if_in` to the next. The high/low duty cycle of `if_in` has no effect on `data_o`.
- R3: An IF period of LOAD_VAL+1 clocks or more produces an overflow (default LOAD_VAL = 999, so 1000 clocks). A period of LOAD_VAL clocks or fewer produces none.
- R4: Each overflow pulse is one clock wide. Only the counter belonging to the divided-signal level that was present in the preceding cycle can pulse.
- R5: A level that persists keeps producing overflows every LOAD_VAL+1 clocks. While `if_in` stops toggling after slow cycles, `data_o` remains 1.
- R6: Any overflow sets `data_o` to 1 from the next cycle. `data_o` holds 1 for exactly STRETCH_LEN cycles (default 1100) after the most recent overflow. N consecutive slow cycles of period P therefore give one high run of (N-1)*P + STRETCH_LEN cycles.
- R7: `data_o` first reads 1 at the (LOAD_VAL+5)-th rising clock edge after the `if_in` rising edge that opens the first long period.
- R8: A tone with period 976 gives `data_o` = 0. Alternating bursts of 1026- and 976-clock periods give high and low runs that depend only on the cycle counts: the low run between bursts is (PS + K*PF) - STRETCH_LEN, where PS = 1026 is the last slow period, PF = 976 is the fast period and K is the number of fast cycles.
- R9: A synchronous reset asserted while `data_o` is 1 makes it 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 1 count per microsecond |
| rst | input | 1 | Synchronous active-high reset |
| if_in | input | 1 | Clipped IF square wave, asynchronous |
| data_o | output | 1 | Demodulated data: 1 for the slow tone, 0 for the fast tone |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `if_in` is a slow wave. Each of its levels must last many clocks, so the toggle stage never sees two rising edges within the synchronizer latency. They also rely on STRETCH_LEN exceeding LOAD_VAL+1, so that a persisting level keeps the output high. The stimulus changes `if_in` only on falling clock edges and holds every level for at least 100 clocks. It applies reset before each scenario and takes its measurements before a trailing, unterminated IF level could reach the threshold.

// File: rtl/fsk_disc_pkg.sv
package fsk_disc_pkg;

    // Polarity of the divided-by-two IF level that a timer watches
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;

    // Bits needed to hold values 0..v
    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/fsk_rise_toggle.sv
module fsk_rise_toggle #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_async,
    output logic tog_o,
    output logic start_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   tog;
    } rt_state_t;

    rt_state_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], in_async};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        rise      = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;
        if (rise) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog_o   = st_q.tog;
    assign start_o = rise;

endmodule

// File: rtl/fsk_level_timer.sv
module fsk_level_timer
    import fsk_disc_pkg::*;
#(
    parameter int     LOAD_VAL = 999,
    parameter level_e LEVEL    = LVL_HIGH
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_i,
    input  logic start_i,
    output logic ovf_o
);

    localparam int CNT_W = cnt_bits(LOAD_VAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             ovf;
    } lt_state_t;

    lt_state_t st_d, st_q;
    logic      active;
    logic      enter;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        active   = st_q.armed && (tog_i == LEVEL);
        enter    = start_i && ((~tog_i) == LEVEL);
        if (enter) begin
            st_d.cnt   = CNT_W'(LOAD_VAL);
            st_d.armed = 1'b1;
        end else if (active) begin
            if (st_q.cnt == '0) begin
                st_d.ovf = 1'b1;
                st_d.cnt = CNT_W'(LOAD_VAL);
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_o = st_q.ovf;

endmodule

// File: rtl/fsk_stretcher.sv
module fsk_stretcher
    import fsk_disc_pkg::*;
#(
    parameter int STRETCH_LEN = 1100
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic out_o
);

    localparam int STR_W = cnt_bits(STRETCH_LEN);

    typedef struct packed {
        logic [STR_W-1:0] cnt;
    } st_state_t;

    st_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.cnt = STR_W'(STRETCH_LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = (st_q.cnt != '0);

endmodule

// File: rtl/fsk_cycle_discriminator.sv
module fsk_cycle_discriminator
    import fsk_disc_pkg::*;
#(
    parameter int LOAD_VAL    = 999,
    parameter int STRETCH_LEN = 1100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic if_in,
    output logic data_o
);

    localparam int NUM_LVL = 2;

    logic               tog;
    logic               start;
    logic [NUM_LVL-1:0] ovf;
    logic               trig;

    fsk_rise_toggle #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_toggle (
        .clk     (clk),
        .rst     (rst),
        .in_async(if_in),
        .tog_o   (tog),
        .start_o (start)
    );

    // One period timer per polarity of the divided signal
    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_timer
            fsk_level_timer #(
                .LOAD_VAL(LOAD_VAL),
                .LEVEL   (level_e'(g))
            ) u_timer (
                .clk    (clk),
                .rst    (rst),
                .tog_i  (tog),
                .start_i(start),
                .ovf_o  (ovf[g])
            );
        end
    endgenerate

    assign trig = |ovf;

    fsk_stretcher #(
        .STRETCH_LEN(STRETCH_LEN)
    ) u_stretch (
        .clk   (clk),
        .rst   (rst),
        .trig_i(trig),
        .out_o (data_o)
    );

endmodule

// File: rtl/fsk_cycle_discriminator_chk.sv
module fsk_cycle_discriminator_chk (
    input logic       clk,
    input logic       rst,
    input logic       tog,
    input logic [1:0] ovf,
    input logic       data_o
);

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> !data_o); // R9

    AST_OVF_HI_WIDTH: assert property (@(posedge clk) disable iff (rst) ovf[1] |=> !ovf[1]); // R4

    AST_OVF_LO_WIDTH: assert property (@(posedge clk) disable iff (rst) ovf[0] |=> !ovf[0]); // R4

    AST_OVF_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0(ovf)); // R4

    AST_OVF_HI_GATED: assert property (@(posedge clk) disable iff (rst) ovf[1] |-> $past(tog)); // R4

    AST_OVF_LO_GATED: assert property (@(posedge clk) disable iff (rst) ovf[0] |-> !$past(tog)); // R4

    AST_TRIG_SETS_OUT: assert property (@(posedge clk) disable iff (rst) (|ovf) |=> data_o); // R6

    AST_FALL_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst) $fell(data_o) |-> ($past(ovf) == 2'b00)); // R6

endmodule

bind fsk_cycle_discriminator fsk_cycle_discriminator_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .tog   (tog),
    .ovf   (ovf),
    .data_o(data_o)
);

// File: tb/fsk_cycle_discriminator_tb.sv
`timescale 1ns/1ps
module fsk_cycle_discriminator_tb;

    localparam int LOAD = 999;
    localparam int STR  = 1100;
    localparam int PS   = 1026;
    localparam int PF   = 976;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic if_in = 1'b0;
    logic data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int rises, falls, rise_cyc, fall_cyc, high_len, low_len;
    logic prev;

    fsk_cycle_discriminator #(
        .LOAD_VAL(LOAD),
        .STRETCH_LEN(STR),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk),
        .rst(rst),
        .if_in(if_in),
        .data_o(data_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Run-length monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            rises = 0; falls = 0; prev = 1'b0;
            rise_cyc = 0; fall_cyc = 0; high_len = 0; low_len = 0;
        end else begin
            if (data_o && !prev) begin
                rises++;
                if (falls > 0) low_len = cyc - fall_cyc;
                rise_cyc = cyc;
            end
            if (!data_o && prev) begin
                falls++;
                fall_cyc = cyc;
                high_len = cyc - rise_cyc;
            end
            prev = data_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        if_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic tone(input int period, input int n, input int hi);
        for (int i = 0; i < n; i++) begin
            if_in = 1'b1;
            repeat (hi) @(negedge clk);
            if_in = 1'b0;
            repeat (period - hi) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        apply_reset();
        chk("R1 out after reset", int'(data_o), 0);
        repeat (3000) @(negedge clk);
        chk("R1 static input rises", rises, 0);
        chk("R1 static input level", int'(data_o), 0);
    endtask

    task automatic t_fast();
        apply_reset();
        tone(PF, 15, PF / 2);
        chk("R8 fast tone rises", rises, 0);
        chk("R8 fast tone level", int'(data_o), 0);
    endtask

    task automatic t_burst();
        int c0;
        apply_reset();
        tone(PF, 3, PF / 2);
        c0 = cyc;
        tone(PS, 4, PS / 2);
        tone(PF, 3, PF / 2);
        chk("R7 rise latency", rise_cyc - c0, LOAD + 5);
        chk("R6 high run", high_len, 3 * PS + STR);
        chk("R6 single run", rises, 1);
        chk("R6 run ended", falls, 1);
    endtask

    task automatic t_bound();
        apply_reset();
        tone(PF, 2, PF / 2);
        tone(LOAD + 1, 4, (LOAD + 1) / 2);
        tone(PF, 3, PF / 2);
        chk("R3 period LOAD+1 rises", rises, 1);
        chk("R3 period LOAD+1 run", high_len, 3 * (LOAD + 1) + STR);
        apply_reset();
        tone(PF, 2, PF / 2);
        tone(LOAD, 4, LOAD / 2);
        tone(PF, 3, PF / 2);
        chk("R3 period LOAD rises", rises, 0);
    endtask

    task automatic t_duty();
        apply_reset();
        tone(PF, 2, 100);
        tone(PS, 3, 200);
        tone(PF, 3, 800);
        chk("R2 skewed duty run", high_len, 2 * PS + STR);
        chk("R2 skewed duty rises", rises, 1);
    endtask

    task automatic t_stuck();
        apply_reset();
        tone(PF, 2, PF / 2);
        tone(PS, 2, PS / 2);
        if_in = 1'b1;
        repeat (6000) @(negedge clk);
        chk("R5 held level stays high", int'(data_o), 1);
        chk("R5 no fall while held", falls, 0);
        chk("R5 single rise", rises, 1);
        // R9: reset while output is high
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset clears output", int'(data_o), 0);
        if_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rate();
        apply_reset();
        tone(PF, 2, PF / 2);
        tone(PS, 10, PS / 2);
        tone(PF, 10, PF / 2);
        chk("R8 long burst run", high_len, 9 * PS + STR);
        tone(PS, 5, PS / 2);
        chk("R8 gap between bursts", low_len, PS + 10 * PF - STR);
        tone(PF, 3, PF / 2);
        chk("R8 short burst run", high_len, 4 * PS + STR);
        chk("R8 burst count", rises, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_burst();
        t_bound();
        t_duty();
        t_stuck();
        t_rate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule